// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Engine

This block is the serial protocol engine of a small non-volatile word memory reached over a three-wire select/clock/data-in link with one data-out line. It is modelled with a register array of 2^ADDR_BITS words of DATA_W bits (512 x 16 by default). A fast system clock samples the select, serial clock and data inputs, so every serial edge is seen as an event a few system cycles after it happens on the wire. The data-out line comes with an enable, so that a pad or the surrounding logic can tri-state it.

A host selects the device and clocks in a frame. The frame holds a start bit, a two-bit opcode and an address field. The engine reads out data as a continuous stream that walks through the array, or it takes one data word and commits it in a timed programming cycle that starts when the select line drops. While that cycle runs, the host can raise the select line and watch data-out for the busy and ready status.

Top module: `mwEeprom`

## Requirements
- R1: While selected and idle, bits sampled as 0 on serial-clock rising edges are skipped. A 1 starts a frame, and the data-out enable stays low before the start bit.
- R2: A frame has a start bit, then a 2-bit opcode MSB first (READ = 10, WRITE = 01), then an ADDR_FIELD-bit address MSB first. Only its low ADDR_BITS bits select a word; the upper bits are don't-care but must be clocked in.
- R3: On the rising edge that carries the last address bit of a READ, data-out becomes enabled and drives one dummy 0. Each later rising edge then presents the next bit of the addressed word, MSB first.
- R4: While select stays high, the bit after a word's LSB is the MSB of the word at the next address, with no dummy bit. The address after the last word is 0.
- R5: A WRITE takes DATA_W data bits MSB first after the address. Programming starts on the falling edge of select, and the whole old word is replaced by the new value with no separate erase.
- R6: For WRITE_CYCLES system clocks after programming starts, data-out is enabled and drives 0 whenever select is high. Any frame clocked in during this time is ignored.
- R7: After the programming cycle, data-out is enabled and drives 1 whenever select is high. A start bit clocked in while this shows keeps data-out driven until the serial-clock falling edge, which drops the enable.
- R8: Opcodes 00 and 11 are ignored: data-out stays disabled and the array is unchanged.
- R9: Dropping select aborts a partly received frame. A WRITE cut off before its last data bit programs nothing and starts no busy period.
- R10: After reset the data-out enable is low and every word reads as 0.
- R11: Data-out is never enabled while the sampled select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial link |
| rstN | input | 1 | Active-low reset |
| csIn | input | 1 | Chip select, active high |
| skIn | input | 1 | Serial clock from the host |
| diIn | input | 1 | Serial data in |
| doOut | output | 1 | Serial data out value |
| doOe | output | 1 | Output enable for doOut; low means high impedance |

## Verification
The bench builds the engine with ADDR_BITS = 4, so the array has sixteen words. The address field stays 10 bits wide, and WRITE_CYCLES is 600. With sixteen words, every location can be written with an arithmetic pattern and read back. A sequential read can cross the wrap from word 15 to word 0 in a few hundred serial clocks. The bench sets nonzero don't-care address bits to show that they alias. The 600-cycle programming time is long enough that a full ignored frame and a second busy poll both fit inside one busy period.

// File: rtl/mwEepromPkg.sv
package mwEepromPkg;

  typedef enum logic [1:0] {
    DO_Z,
    DO_SHIFT,
    DO_BUSY,
    DO_READY
  } doMode_t;

  typedef struct packed {
    logic    shiftAddr;
    logic    shiftData;
    logic    loadRead;
    logic    readStep;
    logic    writeMem;
    doMode_t doMode;
  } mwStrobe_t;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

endpackage

// File: rtl/mwEepromCtrl.sv
module mwEepromCtrl
  import mwEepromPkg::*;
#(
  parameter int ADDR_FIELD   = 10,
  parameter int DATA_W       = 16,
  parameter int WRITE_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csS,
  input  logic       skRise,
  input  logic       skFall,
  input  logic       diS,
  output mwStrobe_t  str
);

  localparam int MAXF   = (DATA_W > ADDR_FIELD) ? DATA_W : ADDR_FIELD;
  localparam int CNT_W  = $clog2(MAXF) + 1;
  localparam int BUSY_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0]  LAST_ADDR = CNT_W'(ADDR_FIELD - 1);
  localparam logic [CNT_W-1:0]  LAST_DATA = CNT_W'(DATA_W - 1);
  localparam logic [BUSY_W-1:0] BUSY_INIT = BUSY_W'(WRITE_CYCLES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_OPC, S_ADDR, S_WDATA, S_WAITCS, S_READ, S_SKIP, S_BUSY, S_READY
  } state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        opc;
  logic [BUSY_W-1:0] busyCnt;
  logic              hiZPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      opc     <= '0;
      busyCnt <= '0;
      hiZPend <= 1'b0;
    end else begin
      if (skFall || !csS) hiZPend <= 1'b0;
      case (state)
        S_IDLE, S_READY: begin
          if (csS && skRise && diS) begin
            hiZPend <= (state == S_READY);
            state   <= S_OPC;
            cnt     <= '0;
          end
        end
        S_OPC: begin
          if (!csS) state <= S_IDLE;
          else if (skRise) begin
            opc <= {opc[0], diS};
            if (cnt == CNT_W'(1)) begin
              state <= S_ADDR;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
        end
        S_ADDR: begin
          if (!csS) state <= S_IDLE;
          else if (skRise) begin
            if (cnt == LAST_ADDR) begin
              cnt <= '0;
              if (opc == OP_READ)       state <= S_READ;
              else if (opc == OP_WRITE) state <= S_WDATA;
              else                      state <= S_SKIP;
            end else cnt <= cnt + 1'b1;
          end
        end
        S_WDATA: begin
          if (!csS) state <= S_IDLE;
          else if (skRise) begin
            if (cnt == LAST_DATA) state <= S_WAITCS;
            else cnt <= cnt + 1'b1;
          end
        end
        S_WAITCS: begin
          if (!csS) begin
            state   <= S_BUSY;
            busyCnt <= BUSY_INIT;
          end
        end
        S_READ, S_SKIP: begin
          if (!csS) state <= S_IDLE;
        end
        S_BUSY: begin
          if (busyCnt == '0) state <= S_READY;
          else busyCnt <= busyCnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    str           = '0;
    str.shiftAddr = (state == S_ADDR)  && csS && skRise;
    str.loadRead  = (state == S_ADDR)  && csS && skRise && (cnt == LAST_ADDR)
                    && (opc == OP_READ);
    str.shiftData = (state == S_WDATA) && csS && skRise;
    str.readStep  = (state == S_READ)  && csS && skRise;
    str.writeMem  = (state == S_WAITCS) && !csS;
    str.doMode    = DO_Z;
    if (csS) begin
      case (state)
        S_READ:  str.doMode = DO_SHIFT;
        S_BUSY:  str.doMode = DO_BUSY;
        S_READY: str.doMode = DO_READY;
        S_OPC:   str.doMode = hiZPend ? DO_READY : DO_Z;
        default: str.doMode = DO_Z;
      endcase
    end
  end

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BUSY) |-> !(str.shiftAddr || str.shiftData || str.readStep || str.loadRead)); // R6

  AST_BUSY_ENDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BUSY && busyCnt == '0) |=> (state == S_READY)); // R7

endmodule

// File: rtl/mwEepromData.sv
module mwEepromData
  import mwEepromPkg::*;
#(
  parameter int ADDR_BITS = 9,
  parameter int DATA_W    = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      diS,
  input  mwStrobe_t str,
  output logic      doOut,
  output logic      doOe
);

  localparam int DEPTH = 1 << ADDR_BITS;
  localparam int WC_W  = $clog2(DATA_W);
  localparam logic [WC_W-1:0] LAST_BIT = WC_W'(DATA_W - 1);

  logic [DATA_W-1:0]    mem [DEPTH];
  logic [ADDR_BITS-1:0] addrSh;
  logic [ADDR_BITS-1:0] rdAddr;
  logic [ADDR_BITS-1:0] nextA;
  logic [ADDR_BITS-1:0] incA;
  logic [DATA_W-1:0]    dataSh;
  logic [DATA_W-1:0]    outSh;
  logic [WC_W-1:0]      wordCnt;
  logic                 doReg;

  assign nextA = {addrSh[ADDR_BITS-2:0], diS};
  assign incA  = rdAddr + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrSh  <= '0;
      rdAddr  <= '0;
      dataSh  <= '0;
      outSh   <= '0;
      wordCnt <= '0;
      doReg   <= 1'b0;
    end else begin
      if (str.shiftAddr) addrSh <= nextA;
      if (str.shiftData) dataSh <= {dataSh[DATA_W-2:0], diS};
      if (str.loadRead) begin
        rdAddr  <= nextA;
        outSh   <= mem[nextA];
        wordCnt <= '0;
        doReg   <= 1'b0;
      end else if (str.readStep) begin
        doReg <= outSh[DATA_W-1];
        if (wordCnt == LAST_BIT) begin
          wordCnt <= '0;
          rdAddr  <= incA;
          outSh   <= mem[incA];
        end else begin
          wordCnt <= wordCnt + 1'b1;
          outSh   <= {outSh[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (str.writeMem) begin
      mem[addrSh] <= dataSh;
    end
  end

  always_comb begin
    doOe  = (str.doMode != DO_Z);
    doOut = 1'b0;
    case (str.doMode)
      DO_SHIFT: doOut = doReg;
      DO_READY: doOut = 1'b1;
      default:  doOut = 1'b0;
    endcase
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(str.readStep || str.loadRead) |=> $stable(rdAddr)); // R4

  AST_BUSY_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (str.doMode == DO_BUSY) |-> (doOe && !doOut)); // R6

endmodule

// File: rtl/mwEeprom.sv
module mwEeprom
  import mwEepromPkg::*;
#(
  parameter int ADDR_BITS    = 9,
  parameter int ADDR_FIELD   = 10,
  parameter int DATA_W       = 16,
  parameter int WRITE_CYCLES = 200,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  output logic doOut,
  output logic doOe
);

  logic [2:0] syncQ [SYNC_STAGES];
  logic       csS, skS, diS, skPrev, skRise, skFall, csPrev;
  mwStrobe_t  str;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= '0;
        else if (g == 0) syncQ[g] <= {csIn, skIn, diIn};
        else syncQ[g] <= syncQ[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign {csS, skS, diS} = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      skPrev <= 1'b0;
      csPrev <= 1'b0;
    end else begin
      skPrev <= skS;
      csPrev <= csS;
    end
  end

  assign skRise = skS & ~skPrev;
  assign skFall = ~skS & skPrev;

  mwEepromCtrl #(
    .ADDR_FIELD  (ADDR_FIELD),
    .DATA_W      (DATA_W),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .csS   (csS),
    .skRise(skRise),
    .skFall(skFall),
    .diS   (diS),
    .str   (str)
  );

  mwEepromData #(
    .ADDR_BITS(ADDR_BITS),
    .DATA_W   (DATA_W)
  ) data_i (
    .clk  (clk),
    .rstN (rstN),
    .diS  (diS),
    .str  (str),
    .doOut(doOut),
    .doOe (doOe)
  );

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.shiftAddr, str.shiftData, str.readStep, str.writeMem})); // R2

  AST_WRITE_AT_CSFALL: assert property (@(posedge clk) disable iff (!rstN)
    str.writeMem |-> (csPrev && !csS)); // R5

  AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ($past(str.loadRead) && csS) |-> (doOe && !doOut)); // R3

  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    doOe |-> csS); // R11

endmodule

// File: tb/mwEeprom_tb_top.sv
module mwEeprom_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AB   = 4;
  localparam int AF   = 10;
  localparam int DW   = 16;
  localparam int WCYC = 600;
  localparam int NW   = 1 << AB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csIn = 1'b0, skIn = 1'b0, diIn = 1'b0;
  logic doOut, doOe;
  int   checks = 0, errors = 0, cycles = 0;
  logic [DW-1:0] model [NW];

  always #(CLK_PERIOD/2) clk = ~clk;

  mwEeprom #(
    .ADDR_BITS(AB), .ADDR_FIELD(AF), .DATA_W(DW), .WRITE_CYCLES(WCYC)
  ) dut_i (
    .clk(clk), .rstN(rstN), .csIn(csIn), .skIn(skIn), .diIn(diIn),
    .doOut(doOut), .doOe(doOe)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return 16'hA5C3 ^ (DW'(i) * 16'h1357);
  endfunction

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic skBit(input logic b);
    @(negedge clk) diIn = b;
    waitClk(3);
    skIn = 1'b1;
    waitClk(6);
    skIn = 1'b0;
    waitClk(6);
  endtask

  task automatic csUp();
    @(negedge clk) csIn = 1'b1;
    waitClk(4);
  endtask

  task automatic csDown();
    @(negedge clk) begin csIn = 1'b0; diIn = 1'b0; end
    waitClk(6);
  endtask

  task automatic header(input logic [1:0] op, input logic [AF-1:0] a);
    skBit(1'b1);
    for (int i = 1; i >= 0; i--) skBit(op[i]);
    for (int i = AF - 1; i >= 0; i--) skBit(a[i]);
  endtask

  task automatic sendWrite(input logic [AF-1:0] a, input logic [DW-1:0] d);
    header(2'b01, a);
    for (int i = DW - 1; i >= 0; i--) skBit(d[i]);
  endtask

  task automatic readSeq(input logic [AF-1:0] a, input int nWords, input string tag);
    logic [DW-1:0] got;
    csUp();
    header(2'b10, a);
    check(doOe && !doOut, "R3 dummy zero", {30'd0, doOe, doOut}, 32'h2);
    for (int w = 0; w < nWords; w++) begin
      int idx;
      idx = (int'(a[AB-1:0]) + w) % NW;
      got = '0;
      for (int i = DW - 1; i >= 0; i--) begin
        skBit(1'b0);
        got[i] = doOut & doOe;
      end
      check(got == model[idx], tag, {16'd0, got}, {16'd0, model[idx]});
    end
    csDown();
    check(!doOe, "R11 oe low after deselect", {31'd0, doOe}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) model[i] = '0;
    waitClk(5);
    check(!doOe, "R10 oe low in reset", {31'd0, doOe}, 32'd0);
    rstN = 1'b1;
    waitClk(5);
    check(!doOe, "R10 oe low after reset", {31'd0, doOe}, 32'd0);

    // R1: leading zeros skipped, then a full read of zero memory
    csUp();
    for (int i = 0; i < 3; i++) skBit(1'b0);
    check(!doOe, "R1 oe low before start", {31'd0, doOe}, 32'd0);
    csDown();
    readSeq(10'd3, 2, "R10 array zero after reset");

    // First write with busy and ready polling
    csUp();
    sendWrite(10'd0, pat(0));
    csDown();
    model[0] = pat(0);
    csUp();
    check(doOe && !doOut, "R6 busy drives 0", {30'd0, doOe, doOut}, 32'h2);
    sendWrite(10'd1, 16'h1234);
    csDown();
    csUp();
    check(doOe && !doOut, "R6 still busy after ignored frame", {30'd0, doOe, doOut}, 32'h2);
    csDown();
    waitClk(WCYC);
    csUp();
    check(doOe && doOut, "R7 ready drives 1", {30'd0, doOe, doOut}, 32'h3);
    @(negedge clk) diIn = 1'b1;
    waitClk(3);
    skIn = 1'b1;
    waitClk(6);
    check(doOe && doOut, "R7 driven until SK falls", {30'd0, doOe, doOut}, 32'h3);
    skIn = 1'b0;
    waitClk(6);
    check(!doOe, "R7 hi-Z after SK fall", {31'd0, doOe}, 32'd0);
    csDown();

    // Fill the rest, with don't-care upper address bits set on odd words (R2)
    for (int i = 1; i < NW; i++) begin
      logic [AF-1:0] a;
      a = AF'(i);
      if (i % 2 == 1) a[AF-1:AB] = '1;
      csUp();
      sendWrite(a, pat(i));
      csDown();
      model[i] = pat(i);
      waitClk(WCYC + 10);
    end
    readSeq(10'd0, NW, "R2 R5 readback of all words");
    readSeq(10'd13, 6, "R4 sequential read across wrap");

    // R5: overwrite replaces every bit
    csUp();
    sendWrite(10'd5, 16'h00F0);
    csDown();
    model[5] = 16'h00F0;
    waitClk(WCYC + 10);
    readSeq(10'd5, 1, "R5 overwrite without erase");

    // R9: write cut off after half the data
    csUp();
    header(2'b01, 10'd7);
    for (int i = 0; i < DW / 2; i++) skBit(1'b1);
    csDown();
    csUp();
    check(!(doOe && !doOut), "R9 no busy after aborted write", {30'd0, doOe, doOut}, 32'h3);
    csDown();
    readSeq(10'd7, 1, "R9 aborted write left word");
    // R9: read aborted in mid-address, then a clean read
    csUp();
    skBit(1'b1); skBit(1'b1); skBit(1'b0); skBit(1'b0);
    csDown();
    readSeq(10'd9, 1, "R9 read after aborted frame");

    // R8: unused opcodes
    for (int op = 0; op < 4; op += 3) begin
      csUp();
      header(2'(op), 10'd2);
      check(!doOe, "R8 oe low for unused opcode", {31'd0, doOe}, 32'd0);
      for (int i = 0; i < DW; i++) skBit(1'b0);
      check(!doOe, "R8 oe low after unused frame", {31'd0, doOe}, 32'd0);
      csDown();
      waitClk(WCYC + 10);
    end
    readSeq(10'd2, 1, "R8 array unchanged");

    summary();
  end

endmodule